// File: doc/BRIEF.md
# Debug Chip-Erase and Unlock Controller

This block is the target-side controller that brings a locked device back into a debuggable state. A debug command decoder gives it key entries, register writes and register reads. The controller drives the system reset and starts a memory-wide erase in a flash controller through a start/done/error handshake. It also holds the lock and status flags. While the device is locked, any system-bus access is refused with an error, and only the controller's own register space stays usable.

To unlock, the host must follow a fixed order. First it enters the 64-bit erase key. Next it asserts system reset through the reset-request register, then releases that reset. The erase is launched at the moment the reset is released, and only if the key is still valid. The host then polls the system-status register until the lock bit clears, and reads the erase-failed bit to learn the outcome. While the erase runs, the brown-out detector is forced on. An erase that reports an error, or that does not finish within `TIMEOUT_CYC` cycles, is marked failed and leaves the device locked.

Top module: `dbg_erase_ctrl`

## Requirements
- R1: On synchronous reset, the key flag, the reset output, erase-failed, busy and the brown-out force output are all 0. The lock bit takes the value of `lock_cfg_i`.
- R2: A key entry equal to 64'h4E564D4572617365 sets the key flag, read at address 0 bit 0, on the next cycle. Any other key value clears the flag.
- R3: Writing 8'h59 to address 1 asserts `sys_rst_o` on the next cycle, and writing 8'h00 releases it. Any other value has no effect. Address 1 bit 0 reads back the reset state.
- R4: A write of 8'h00 to address 1 while `sys_rst_o` is high and the key flag is set produces a one-cycle `erase_start_o` pulse in the same cycle that `sys_rst_o` falls, and clears the key flag. If the key flag is clear, no erase starts and the status does not change.
- R5: Address 2 is the status register: bit 0 is lock, bit 1 is erase-failed, bit 2 is busy. From the start of an erase, lock and busy read 1. Address 3 reads 0.
- R6: An `erase_done_i` without `erase_err_i` during an erase clears busy, lock and erase-failed on the next cycle.
- R7: An `erase_done_i` with `erase_err_i` during an erase clears busy and sets erase-failed. Lock stays 1.
- R8: An erase that gets no done within `TIMEOUT_CYC` cycles ends with busy 0, erase-failed 1 and lock 1.
- R9: `bod_force_o` is high exactly while an erase is busy.
- R10: A system-bus request is answered one cycle later with `sys_ack_o`. `sys_err_o` is set if the device was locked, and clear otherwise. A request changes no register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_cfg_i | input | 1 | Lock value loaded at reset |
| key_valid_i | input | 1 | Key entry strobe |
| key_data_i | input | 64 | Key value |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for reads and writes |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| sys_req_i | input | 1 | System-bus access request |
| sys_ack_o | output | 1 | System-bus response, one cycle after request |
| sys_err_o | output | 1 | Response error (request made while locked) |
| sys_rst_o | output | 1 | System reset output |
| erase_start_o | output | 1 | One-cycle erase launch pulse to the flash controller |
| erase_done_i | input | 1 | Erase completion from the flash controller |
| erase_err_i | input | 1 | Error qualifier sampled with `erase_done_i` |
| bod_force_o | output | 1 | Forces the brown-out detector on during an erase |

## Verification
Several properties are checked on every cycle:
- a launch pulse coincides with the fall of reset, and the key flag is clear at that point;
- reset can only rise after a write of the signature;
- the brown-out force implies lock;
- the lock outcome follows each done response;
- locked requests are answered with an error.

Other behaviours are shown only by the bench scenarios:
- mismatching keys are refused;
- ignored reset values leave the reset unchanged;
- a release without a key has no effect;
- the timeout fires only after its full window;
- the lock value loaded at reset follows the configuration input.

// File: rtl/dbg_erase_pkg.sv
// Package: shared constants and register map for the chip-erase controller.
// Assumes an 8-bit register path and a 64-bit key path.
package dbg_erase_pkg;
    localparam logic [63:0] ERASE_KEY = 64'h4E564D4572617365;
    localparam logic [7:0]  RST_SIG   = 8'h59;
    localparam logic [7:0]  RST_CLR   = 8'h00;

    typedef enum logic [1:0] {
        ADDR_KEY  = 2'd0,
        ADDR_RST  = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_RSVD = 2'd3
    } reg_addr_e;

    localparam int STAT_LOCK = 0;
    localparam int STAT_FAIL = 1;
    localparam int STAT_BUSY = 2;
endpackage

// File: rtl/erase_key_latch.sv
// Holds the chip-erase key flag. The flag is set by a matching key entry,
// cleared by a mismatching one, and cleared when an erase launches.
// Assumes key_valid_i is a single-cycle strobe.
module erase_key_latch
    import dbg_erase_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_valid_i,
    input  logic [63:0] key_data_i,
    input  logic        clr_i,
    output logic        flag_o
);
    logic flag_q;

    // Key flag update; a launch clear takes priority over a new entry.
    always_ff @(posedge clk) begin
        if (!rst_n)           flag_q <= 1'b0;
        else if (clr_i)       flag_q <= 1'b0;
        else if (key_valid_i) flag_q <= (key_data_i == ERASE_KEY);
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/rst_req_reg.sv
// Reset-request register. The signature asserts the system reset and zero
// releases it; other values are ignored. It flags the releasing write.
// Assumes wr_i is already qualified by the register address.
module rst_req_reg
    import dbg_erase_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [7:0] wdata_i,
    output logic       sys_rst_o,
    output logic       release_o
);
    logic rst_q;

    // Reset state update from signature and clear writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                              rst_q <= 1'b0;
        else if (wr_i && wdata_i == RST_SIG)     rst_q <= 1'b1;
        else if (wr_i && wdata_i == RST_CLR)     rst_q <= 1'b0;
    end

    // Releasing write: clear value while reset is held.
    always_comb release_o = wr_i && (wdata_i == RST_CLR) && rst_q;

    assign sys_rst_o = rst_q;
endmodule

// File: rtl/erase_seq.sv
// Erase sequencer: launches the erase on reset release with a valid key,
// tracks busy with a timeout, and owns the lock and erase-failed flags.
// Assumes done_i/err_i are meaningful only while busy.
module erase_seq #(
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_cfg_i,
    input  logic release_i,
    input  logic key_flag_i,
    input  logic done_i,
    input  logic err_i,
    output logic launch_o,
    output logic start_o,
    output logic busy_o,
    output logic lock_o,
    output logic failed_o
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYC - 1);

    logic          busy_q, lock_q, failed_q, start_q;
    logic [CW-1:0] cnt_q;

    // Launch condition: idle, reset being released, key present.
    always_comb launch_o = !busy_q && release_i && key_flag_i;

    // Sequencer state, timeout counter and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            lock_q   <= lock_cfg_i;
            failed_q <= 1'b0;
            start_q  <= 1'b0;
            cnt_q    <= '0;
        end else begin
            start_q <= 1'b0;
            if (!busy_q) begin
                if (launch_o) begin
                    start_q  <= 1'b1;
                    busy_q   <= 1'b1;
                    lock_q   <= 1'b1;
                    failed_q <= 1'b0;
                    cnt_q    <= '0;
                end
            end else if (done_i) begin
                busy_q <= 1'b0;
                if (err_i) begin
                    failed_q <= 1'b1;
                end else begin
                    lock_q   <= 1'b0;
                    failed_q <= 1'b0;
                end
            end else if (cnt_q == CNT_LAST) begin
                busy_q   <= 1'b0;
                failed_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign start_o  = start_q;
    assign busy_o   = busy_q;
    assign lock_o   = lock_q;
    assign failed_o = failed_q;
endmodule

// File: rtl/sys_access_gate.sv
// Answers system-bus requests one cycle later, with an error while locked.
// It changes no state of the controller. Assumes single-cycle requests.
module sys_access_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic lock_i,
    output logic ack_o,
    output logic err_o
);
    // Registered response with the lock-based error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o <= 1'b0;
            err_o <= 1'b0;
        end else begin
            ack_o <= req_i;
            err_o <= req_i && lock_i;
        end
    end
endmodule

// File: rtl/dbg_erase_ctrl.sv
// Top of the debug chip-erase controller. It decodes register writes,
// muxes register reads, and wires together the key latch, the reset
// register, the erase sequencer and the access gate.
// Assumes one register operation per cycle; reads are combinational.
module dbg_erase_ctrl
    import dbg_erase_pkg::*;
#(
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lock_cfg_i,
    input  logic        key_valid_i,
    input  logic [63:0] key_data_i,
    input  logic        reg_wr_i,
    input  logic [1:0]  reg_addr_i,
    input  logic [7:0]  reg_wdata_i,
    output logic [7:0]  reg_rdata_o,
    input  logic        sys_req_i,
    output logic        sys_ack_o,
    output logic        sys_err_o,
    output logic        sys_rst_o,
    output logic        erase_start_o,
    input  logic        erase_done_i,
    input  logic        erase_err_i,
    output logic        bod_force_o
);
    logic key_flag_w, release_w, launch_w, busy_w, lock_w, failed_w;
    logic rst_wr_w;

    // Write decode for the reset-request register.
    always_comb rst_wr_w = reg_wr_i && (reg_addr_i == ADDR_RST);

    erase_key_latch u_key (
        .clk(clk), .rst_n(rst_n), .key_valid_i(key_valid_i),
        .key_data_i(key_data_i), .clr_i(launch_w), .flag_o(key_flag_w)
    );

    rst_req_reg u_rst (
        .clk(clk), .rst_n(rst_n), .wr_i(rst_wr_w), .wdata_i(reg_wdata_i),
        .sys_rst_o(sys_rst_o), .release_o(release_w)
    );

    erase_seq #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .lock_cfg_i(lock_cfg_i),
        .release_i(release_w), .key_flag_i(key_flag_w),
        .done_i(erase_done_i), .err_i(erase_err_i),
        .launch_o(launch_w), .start_o(erase_start_o), .busy_o(busy_w),
        .lock_o(lock_w), .failed_o(failed_w)
    );

    sys_access_gate u_gate (
        .clk(clk), .rst_n(rst_n), .req_i(sys_req_i), .lock_i(lock_w),
        .ack_o(sys_ack_o), .err_o(sys_err_o)
    );

    // Register read mux.
    always_comb begin
        reg_rdata_o = 8'h00;
        case (reg_addr_i)
            ADDR_KEY:  reg_rdata_o[0] = key_flag_w;
            ADDR_RST:  reg_rdata_o[0] = sys_rst_o;
            ADDR_STAT: begin
                reg_rdata_o[STAT_LOCK] = lock_w;
                reg_rdata_o[STAT_FAIL] = failed_w;
                reg_rdata_o[STAT_BUSY] = busy_w;
            end
            default:   reg_rdata_o = 8'h00;
        endcase
    end

    assign bod_force_o = busy_w;
endmodule

// File: rtl/dbg_erase_ctrl_chk.sv
// Checker for dbg_erase_ctrl, bound to the top and reading its internal flags.
module dbg_erase_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr_i,
    input logic [1:0] reg_addr_i,
    input logic [7:0] reg_wdata_i,
    input logic       sys_req_i,
    input logic       sys_ack_o,
    input logic       sys_err_o,
    input logic       sys_rst_o,
    input logic       erase_start_o,
    input logic       erase_done_i,
    input logic       erase_err_i,
    input logic       bod_force_o,
    input logic       key_flag,
    input logic       lock,
    input logic       failed
);
    // R4
    launch_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start_o |-> $fell(sys_rst_o));
    // R4
    key_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start_o |-> !key_flag);
    // R3
    rst_needs_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_o) |-> $past(reg_wr_i && reg_addr_i == 2'd1 && reg_wdata_i == 8'h59));
    // R9
    bod_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bod_force_o |-> lock);
    // R6
    unlock_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bod_force_o && erase_done_i && !erase_err_i) |=> (!lock && !failed && !bod_force_o));
    // R7
    stay_locked_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bod_force_o && erase_done_i && erase_err_i) |=> (lock && failed && !bod_force_o));
    // R10
    locked_access_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_req_i && lock) |=> (sys_ack_o && sys_err_o));
endmodule

bind dbg_erase_ctrl dbg_erase_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .sys_req_i(sys_req_i), .sys_ack_o(sys_ack_o),
    .sys_err_o(sys_err_o), .sys_rst_o(sys_rst_o), .erase_start_o(erase_start_o),
    .erase_done_i(erase_done_i), .erase_err_i(erase_err_i),
    .bod_force_o(bod_force_o), .key_flag(key_flag_w), .lock(lock_w),
    .failed(failed_w)
);

// File: tb/dbg_erase_ctrl_tb.sv
module dbg_erase_ctrl_tb;
    localparam int TMO = 32;
    localparam logic [63:0] GOOD_KEY = 64'h4E564D4572617365;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_cfg_i = 1'b1;
    logic        key_valid_i = 1'b0;
    logic [63:0] key_data_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [1:0]  reg_addr_i = '0;
    logic [7:0]  reg_wdata_i = '0;
    logic [7:0]  reg_rdata_o;
    logic        sys_req_i = 1'b0;
    logic        sys_ack_o, sys_err_o, sys_rst_o, erase_start_o, bod_force_o;
    logic        erase_done_i = 1'b0;
    logic        erase_err_i = 1'b0;

    int checks = 0;
    int errors = 0;
    bit exp_key, exp_rst;

    always #10 clk = ~clk;

    dbg_erase_ctrl #(.TIMEOUT_CYC(TMO)) u_dut (.*);

    function automatic bit key_match(logic [63:0] k);
        return k == GOOD_KEY;
    endfunction

    function automatic bit rst_model(bit cur, logic [7:0] d);
        if (d == 8'h59) return 1'b1;
        if (d == 8'h00) return 1'b0;
        return cur;
    endfunction

    // status word: {busy, failed, lock}
    function automatic logic [7:0] stat(bit busy, bit failed, bit lock);
        return {5'b0, busy, failed, lock};
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        reg_addr_i = a;
        #1 d = reg_rdata_o;
    endtask

    task automatic chk_reg(logic [1:0] a, logic [7:0] exp, string req);
        logic [7:0] d;
        rd(a, d);
        chk(d == exp, req, d, exp);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic key(logic [63:0] k);
        key_valid_i = 1'b1; key_data_i = k;
        @(negedge clk);
        key_valid_i = 1'b0;
    endtask

    task automatic sys_access(bit exp_err, string req);
        sys_req_i = 1'b1;
        @(negedge clk);
        sys_req_i = 1'b0;
        chk(sys_ack_o === 1'b1, req, sys_ack_o, 1);
        chk(sys_err_o === exp_err, req, sys_err_o, exp_err);
    endtask

    task automatic finish_erase(bit err);
        erase_done_i = 1'b1; erase_err_i = err;
        @(negedge clk);
        erase_done_i = 1'b0; erase_err_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state with lock configured
        chk_reg(2'd0, 8'h00, "R1 key");
        chk_reg(2'd1, 8'h00, "R1 rst");
        chk_reg(2'd2, stat(0, 0, 1), "R1 stat");
        chk(bod_force_o === 1'b0, "R1 bod", bod_force_o, 0);
        // R5 reserved address
        chk_reg(2'd3, 8'h00, "R5 rsvd");
        // R10 locked access: error, no side effects
        sys_access(1'b1, "R10 locked");
        chk_reg(2'd2, stat(0, 0, 1), "R10 no side effect");

        // Random key entries and non-zero reset writes (R2, R3)
        exp_key = 0; exp_rst = 0;
        for (int i = 0; i < 150; i++) begin
            int op = $urandom % 4;
            case (op)
                0: begin key(GOOD_KEY); exp_key = 1; end
                1: begin
                    logic [63:0] k = {$urandom, $urandom};
                    key(k); exp_key = key_match(k);
                end
                2: begin wr(2'd1, 8'h59); exp_rst = rst_model(exp_rst, 8'h59); end
                default: begin
                    v = 8'($urandom);
                    if (v == 8'h00 || v == 8'h59) v = 8'h5A;
                    wr(2'd1, v); exp_rst = rst_model(exp_rst, v);
                end
            endcase
            chk_reg(2'd0, {7'b0, exp_key}, "R2 key flag");
            chk_reg(2'd1, {7'b0, exp_rst}, "R3 rst bit");
            chk(sys_rst_o === exp_rst, "R3 rst pin", sys_rst_o, exp_rst);
            chk(bod_force_o === 1'b0, "R9 bod idle", bod_force_o, 0);
        end

        // R4 release without key: no erase
        wr(2'd1, 8'h59);
        key(64'h0123456789ABCDEF);
        chk_reg(2'd0, 8'h00, "R2 bad key");
        wr(2'd1, 8'h00);
        chk(erase_start_o === 1'b0, "R4 no key no start", erase_start_o, 0);
        chk(sys_rst_o === 1'b0, "R3 release", sys_rst_o, 0);
        chk_reg(2'd2, stat(0, 0, 1), "R4 status unchanged");

        // R4/R5/R7 erase that reports error
        key(GOOD_KEY);
        chk_reg(2'd0, 8'h01, "R2 good key");
        wr(2'd1, 8'h59);
        chk(sys_rst_o === 1'b1, "R3 assert", sys_rst_o, 1);
        wr(2'd1, 8'h00);
        chk(erase_start_o === 1'b1, "R4 start", erase_start_o, 1);
        chk(sys_rst_o === 1'b0, "R4 rst fell", sys_rst_o, 0);
        chk_reg(2'd0, 8'h00, "R4 key cleared");
        chk_reg(2'd2, stat(1, 0, 1), "R5 busy lock");
        chk(bod_force_o === 1'b1, "R9 bod on", bod_force_o, 1);
        @(negedge clk);
        chk(erase_start_o === 1'b0, "R4 pulse one cycle", erase_start_o, 1'b0);
        repeat (4) @(negedge clk);
        finish_erase(1'b1);
        chk_reg(2'd2, stat(0, 1, 1), "R7 error keeps lock");
        chk(bod_force_o === 1'b0, "R9 bod off", bod_force_o, 0);

        // R8 timeout
        key(GOOD_KEY);
        wr(2'd1, 8'h59);
        wr(2'd1, 8'h00);
        chk_reg(2'd2, stat(1, 0, 1), "R8 restart clears fail");
        repeat (20) @(negedge clk);
        chk_reg(2'd2, stat(1, 0, 1), "R8 not yet timed out");
        repeat (20) @(negedge clk);
        chk_reg(2'd2, stat(0, 1, 1), "R8 timeout");
        chk(bod_force_o === 1'b0, "R9 bod after timeout", bod_force_o, 0);

        // R6 successful erase, then unlocked access
        key(GOOD_KEY);
        wr(2'd1, 8'h59);
        wr(2'd1, 8'h00);
        chk(erase_start_o === 1'b1, "R4 start again", erase_start_o, 1);
        repeat (3) @(negedge clk);
        sys_access(1'b1, "R10 during erase");
        finish_erase(1'b0);
        chk_reg(2'd2, stat(0, 0, 0), "R6 unlocked");
        sys_access(1'b0, "R10 unlocked");

        // R1 reset with lock configuration low
        rst_n = 1'b0; lock_cfg_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk_reg(2'd2, stat(0, 0, 0), "R1 lock cfg low");
        chk_reg(2'd1, 8'h00, "R1 rst after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule